// File: doc/BRIEF.md
# Error-Checked Inversion Decoder for Paired Memory Beats

This block sits on the read path of a memory controller. Data was stored in low-power form: each 64-bit word was split into three groups, and any group could be stored inverted, with one flag bit per group recording the choice. Two such beats make one block. The block carries a single 10-bit check field that protects all 134 payload bits, data and flags alike. The decoder collects the two beats of a block. It checks and repairs the whole payload, then undoes the inversion of each group using the repaired flags. Because the flags are repaired first, a single upset on a flag cannot spread into a whole group of wrong data bits.

The code is a shortened Hamming code with 8 position bits, plus a 2-bit parity field. The parity field makes the total weight of the block even. When the payload position and the overall parity agree on a single upset, that upset is repaired. When they do not agree, the block is reported as unrepairable and passes through as received. Results leave in arrival order, one cycle after the second beat of each block.

Top module: `dbi_secded_rx`

## Requirements
- R1: After reset, `out_valid_o`, `err_corr_o` and `err_uncorr_o` are 0. The next accepted beat is taken as the first beat of a block.
- R2: Accepted beats (`beat_valid_i`=1) alternate between first and second beat. Idle cycles between them are allowed. `out_valid_o` is 1 for exactly the one cycle after a second beat is accepted, and a lone first beat produces no output.
- R3: Beat layout. Bits [63:0] hold data, in groups [21:0], [43:22] and [63:44]. Bits [66:64] are the inversion flags of groups 0, 1 and 2. Bits [71:67] are check bits. A group whose flag is 1 is output bit-wise inverted, and a group whose flag is 0 is output unchanged. The first beat yields `word0_o` and the second yields `word1_o`.
- R4: Code definition.
  - Payload index i runs over bits [66:0] of the first beat (i = 0..66), then bits [66:0] of the second beat (i = 67..133).
  - Payload bit i has code position p(i). This is the (i+1)-th integer of 3 or more that is not a power of two.
  - The 8 Hamming bits are the XOR of p(i) over all payload bits that are 1. Hamming bits 0..4 sit in bits [71:67] of the first beat, and bits 5..7 sit in bits [69:67] of the second beat.
  - Bits [71:70] of the second beat are the parity field, set so that the whole 144-bit block has even weight.
  - A block that follows these rules is output with both error flags at 0.
- R5: A single flipped data bit is repaired, and `err_corr_o`=1.
- R6: A single flipped inversion flag is repaired before the group is restored, so the original word is output and `err_corr_o`=1.
- R7: A single flipped Hamming or parity bit sets `err_corr_o`=1 and leaves both output words equal to the original data.
- R8: Two flipped bits (nonzero syndrome, even block weight) set `err_uncorr_o`=1 and `err_corr_o`=0. No bit is repaired: groups are restored with the received flags.
- R9: An odd block weight with a syndrome above the largest payload position (142) is treated as unrepairable. `err_uncorr_o`=1, and the payload is not changed.
- R10: Back-to-back blocks with no idle beats are output in arrival order, in two separate valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | Beat on `beat_i` is accepted this cycle |
| beat_i | input | 72 | Received beat: data, flags, check bits |
| word0_o | output | 64 | Restored word from the first beat |
| word1_o | output | 64 | Restored word from the second beat |
| out_valid_o | output | 1 | Output words and error flags are valid |
| err_corr_o | output | 1 | A single upset was found and handled |
| err_uncorr_o | output | 1 | The block could not be repaired |

## Verification
Repair of an inversion flag and restoration of the group that flag governs happen in the same cycle. The bench provokes this by flipping the stored flag of a group that was written inverted. A repair that arrived too late would show up as 22 wrong bits instead of one. The result is judged by comparing the output word with the original word, and by checking that only the repairable flag is raised. A second overlap is also tested: an output cycle and the first beat of the next block fall in the same cycle, which happens when blocks arrive back to back.

// File: rtl/dbi_secded_pkg.sv
package dbi_secded_pkg;

   // outcome of the check on one block
   typedef enum logic [1:0] {
      ECC_CLEAN = 2'd0,
      ECC_FIXED = 2'd1,
      ECC_FATAL = 2'd2
   } ecc_class_e;

   // code position of payload bit idx: the (idx+1)-th integer >= 3 that is
   // not a power of two (powers of two are the Hamming bit positions)
   function automatic int unsigned pos_of(input int unsigned idx);
      int unsigned p;
      int unsigned left;
      p = 2;
      left = idx + 1;
      while (left != 0) begin
         p++;
         if ((p & (p - 1)) != 0) left--;
      end
      return p;
   endfunction

   // start bit of group g within a data word
   function automatic int unsigned grp_lo(input int unsigned g,
                                          input int unsigned w0,
                                          input int unsigned w1);
      return (g == 0) ? 0 : (g == 1) ? w0 : (w0 + w1);
   endfunction

   // width of group g within a data word of width dw
   function automatic int unsigned grp_w(input int unsigned g,
                                         input int unsigned dw,
                                         input int unsigned w0,
                                         input int unsigned w1);
      return (g == 0) ? w0 : (g == 1) ? w1 : (dw - w0 - w1);
   endfunction

endpackage

// File: rtl/dbi_beat_pair.sv
module dbi_beat_pair #(
   parameter int unsigned BEAT_W = 72
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  valid_i,
   input  logic [BEAT_W-1:0]     beat_i,
   output logic                  have_first_o,
   output logic                  blk_valid_o,
   output logic [2*BEAT_W-1:0]   blk_o
);

   logic              half_q;
   logic [BEAT_W-1:0] first_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_q  <= 1'b0;
         first_q <= '0;
      end else if (valid_i) begin
         half_q <= ~half_q;
         if (!half_q) first_q <= beat_i;
      end
   end

   assign have_first_o = half_q;
   assign blk_valid_o  = valid_i && half_q;
   assign blk_o        = {beat_i, first_q};

endmodule

// File: rtl/dbi_secded_fix.sv
module dbi_secded_fix
   import dbi_secded_pkg::*;
#(
   parameter int unsigned BEAT_W = 72,
   parameter int unsigned PB_W   = 67,
   parameter int unsigned CHK_W  = 5
) (
   input  logic [2*BEAT_W-1:0]   blk_i,
   output logic [2*PB_W-1:0]     pay_o,
   output ecc_class_e            cls_o
);

   localparam int unsigned PAY_W   = 2 * PB_W;
   localparam int unsigned FIELD_W = 2 * CHK_W;
   localparam int unsigned HAM_W   = FIELD_W - 2;
   localparam int unsigned MAX_POS = pos_of(PAY_W - 1);

   logic [PAY_W-1:0]               pay_rx;
   logic [FIELD_W-1:0]             field_rx;
   logic [HAM_W-1:0]               ham_rx;
   logic [PAY_W-1:0][HAM_W-1:0]    contrib;
   logic [HAM_W-1:0]               syn;
   logic                           odd;
   logic                           in_range;
   logic                           do_fix;
   logic [PAY_W-1:0]               flip;

   assign pay_rx   = {blk_i[BEAT_W +: PB_W], blk_i[0 +: PB_W]};
   assign field_rx = {blk_i[BEAT_W + PB_W +: CHK_W], blk_i[PB_W +: CHK_W]};
   assign ham_rx   = field_rx[HAM_W-1:0];
   assign odd      = ^blk_i;

   for (genvar i = 0; i < PAY_W; i++) begin : g_bit
      localparam logic [HAM_W-1:0] POS = HAM_W'(pos_of(i));
      assign contrib[i] = pay_rx[i] ? POS : '0;
      assign flip[i]    = do_fix && (syn == POS);
   end

   always_comb begin
      syn = ham_rx;
      for (int unsigned i = 0; i < PAY_W; i++) syn ^= contrib[i];
   end

   assign in_range = (32'(syn) <= MAX_POS);
   assign do_fix   = odd && in_range;

   always_comb begin
      if (odd) cls_o = in_range ? ECC_FIXED : ECC_FATAL;
      else     cls_o = (syn != '0) ? ECC_FATAL : ECC_CLEAN;
   end

   assign pay_o = pay_rx ^ flip;

endmodule

// File: rtl/dbi_group_restore.sv
module dbi_group_restore
   import dbi_secded_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned G0_W   = 22,
   parameter int unsigned G1_W   = 22
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [2:0]        flag_i,
   output logic [DATA_W-1:0] data_o
);

   for (genvar g = 0; g < 3; g++) begin : g_grp
      localparam int unsigned LO = grp_lo(g, G0_W, G1_W);
      localparam int unsigned GW = grp_w(g, DATA_W, G0_W, G1_W);
      assign data_o[LO +: GW] = flag_i[g] ? ~data_i[LO +: GW] : data_i[LO +: GW];
   end

endmodule

// File: rtl/dbi_secded_rx.sv
module dbi_secded_rx
   import dbi_secded_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned G0_W   = 22,
   parameter int unsigned G1_W   = 22,
   parameter int unsigned CHK_W  = 5
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                beat_valid_i,
   input  logic [DATA_W+3+CHK_W-1:0] beat_i,
   output logic [DATA_W-1:0]   word0_o,
   output logic [DATA_W-1:0]   word1_o,
   output logic                out_valid_o,
   output logic                err_corr_o,
   output logic                err_uncorr_o
);

   localparam int unsigned PB_W   = DATA_W + 3;
   localparam int unsigned BEAT_W = PB_W + CHK_W;
   localparam int unsigned PAY_W  = 2 * PB_W;
   localparam int unsigned HAM_W  = 2 * CHK_W - 2;

   if (G0_W + G1_W >= DATA_W) begin : g_bad_groups
      $error("group widths leave no room for the third group");
   end
   if (CHK_W < 3) begin : g_bad_chk
      $error("check field too small for position and parity bits");
   end
   if (pos_of(PAY_W - 1) >= (1 << HAM_W)) begin : g_bad_cap
      $error("Hamming bits cannot address every payload bit");
   end

   logic                have_first;
   logic                blk_valid;
   logic [2*BEAT_W-1:0] blk;
   logic [PAY_W-1:0]    pay_fix;
   ecc_class_e          cls;
   logic [1:0][DATA_W-1:0] restored;

   dbi_beat_pair #(.BEAT_W(BEAT_W)) u_pair (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .valid_i      (beat_valid_i),
      .beat_i       (beat_i),
      .have_first_o (have_first),
      .blk_valid_o  (blk_valid),
      .blk_o        (blk)
   );

   dbi_secded_fix #(.BEAT_W(BEAT_W), .PB_W(PB_W), .CHK_W(CHK_W)) u_fix (
      .blk_i (blk),
      .pay_o (pay_fix),
      .cls_o (cls)
   );

   for (genvar b = 0; b < 2; b++) begin : g_beat
      dbi_group_restore #(.DATA_W(DATA_W), .G0_W(G0_W), .G1_W(G1_W)) u_rest (
         .data_i (pay_fix[b*PB_W +: DATA_W]),
         .flag_i (pay_fix[b*PB_W + DATA_W +: 3]),
         .data_o (restored[b])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o  <= 1'b0;
         err_corr_o   <= 1'b0;
         err_uncorr_o <= 1'b0;
         word0_o      <= '0;
         word1_o      <= '0;
      end else begin
         out_valid_o  <= blk_valid;
         err_corr_o   <= blk_valid && (cls == ECC_FIXED);
         err_uncorr_o <= blk_valid && (cls == ECC_FATAL);
         if (blk_valid) begin
            word0_o <= restored[0];
            word1_o <= restored[1];
         end
      end
   end

endmodule

// File: rtl/dbi_secded_rx_chk.sv
module dbi_secded_rx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic beat_valid_i,
   input logic have_first,
   input logic out_valid_o,
   input logic err_corr_o,
   input logic err_uncorr_o
);

   // R2
   out_after_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> ($past(beat_valid_i) && $past(have_first)));

   // R2
   pair_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (beat_valid_i && !have_first) |=> have_first);

   // R10
   no_double_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |=> !out_valid_o);

   // R8
   err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(err_corr_o && err_uncorr_o));

   // R1
   err_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_corr_o || err_uncorr_o) |-> out_valid_o);

endmodule

bind dbi_secded_rx dbi_secded_rx_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .beat_valid_i (beat_valid_i),
   .have_first   (have_first),
   .out_valid_o  (out_valid_o),
   .err_corr_o   (err_corr_o),
   .err_uncorr_o (err_uncorr_o)
);

// File: tb/sim_dbi_secded_rx.sv
module sim_dbi_secded_rx;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bv = 1'b0;
   logic [71:0] beat = '0;
   logic [63:0] w0, w1;
   logic        ov, ec, eu;
   int          total = 0;
   int          bad = 0;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbi_secded_rx u0 (
      .clk_i (clk), .rst_ni (rst_n), .beat_valid_i (bv), .beat_i (beat),
      .word0_o (w0), .word1_o (w1), .out_valid_o (ov),
      .err_corr_o (ec), .err_uncorr_o (eu)
   );

   function automatic int bpos(input int idx);
      int p = 2;
      int left = idx + 1;
      while (left != 0) begin
         p++;
         if ((p & (p - 1)) != 0) left--;
      end
      return p;
   endfunction

   function automatic logic [63:0] apply_inv(input logic [63:0] w, input logic [2:0] f);
      logic [63:0] m = '0;
      if (f[0]) m[21:0]  = '1;
      if (f[1]) m[43:22] = '1;
      if (f[2]) m[63:44] = '1;
      return w ^ m;
   endfunction

   // bench-side encoder following R3/R4; returns {second beat, first beat}
   function automatic logic [143:0] enc(input logic [63:0] a, input logic [63:0] b,
                                        input logic [2:0] fa, input logic [2:0] fb);
      logic [133:0] pay;
      logic [7:0]   h = '0;
      logic [71:0]  b0, b1;
      pay = {fb, apply_inv(b, fb), fa, apply_inv(a, fa)};
      for (int i = 0; i < 134; i++) if (pay[i]) h ^= 8'(bpos(i));
      b0 = {h[4:0], pay[66:0]};
      b1 = {2'b00, h[7:5], pay[133:67]};
      b1[70] = ^b0;
      b1[71] = ^b1[69:0];
      return {b1, b0};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive both beats, then sample one negedge later (output register)
   task automatic send(input logic [143:0] blk);
      @(negedge clk); bv = 1'b1; beat = blk[71:0];
      @(negedge clk); check("R2 no output after first beat", 64'(ov), 64'd0);
      beat = blk[143:72];
      @(negedge clk); bv = 1'b0; beat = '0;
   endtask

   task automatic expect_out(input string req, input logic [63:0] e0, input logic [63:0] e1,
                             input logic c, input logic u);
      check({req, " valid"}, 64'(ov), 64'd1);
      check({req, " word0"}, w0, e0);
      check({req, " word1"}, w1, e1);
      check({req, " corr"},  64'(ec), 64'(c));
      check({req, " uncorr"}, 64'(eu), 64'(u));
   endtask

   task automatic t_reset();
      check("R1 valid after reset", 64'(ov), 64'd0);
      check("R1 corr after reset", 64'(ec), 64'd0);
      check("R1 uncorr after reset", 64'(eu), 64'd0);
   endtask

   task automatic t_clean();
      logic [63:0] a = 64'h0123_4567_89AB_CDEF;
      logic [63:0] b = 64'hFEDC_BA98_7654_3210;
      send(enc(a, b, 3'b000, 3'b000)); expect_out("R3 R4 clean flags 000", a, b, 0, 0);
      send(enc(a, b, 3'b111, 3'b101)); expect_out("R3 R4 clean flags 111/101", a, b, 0, 0);
      send(enc(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b010, 3'b011));
      expect_out("R3 R4 clean extremes", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
   endtask

   task automatic t_lone_beat();
      logic [63:0] a = 64'hDEAD_BEEF_0000_1111;
      logic [63:0] b = 64'h5555_AAAA_3333_CCCC;
      logic [143:0] blk = enc(a, b, 3'b100, 3'b001);
      @(negedge clk); bv = 1'b1; beat = blk[71:0];
      @(negedge clk); bv = 1'b0; beat = '0;
      repeat (3) begin
         @(negedge clk); check("R2 lone first beat gives no output", 64'(ov), 64'd0);
      end
      bv = 1'b1; beat = blk[143:72];
      @(negedge clk); bv = 1'b0; beat = '0;
      expect_out("R2 second beat after gap", a, b, 0, 0);
      @(negedge clk); check("R2 single valid cycle", 64'(ov), 64'd0);
   endtask

   task automatic t_data_err();
      logic [63:0] a = 64'h1357_9BDF_2468_ACE0;
      logic [63:0] b = 64'h0F0F_F0F0_1234_8765;
      logic [143:0] blk = enc(a, b, 3'b001, 3'b110);
      blk[5] = ~blk[5];
      send(blk); expect_out("R5 first beat data bit", a, b, 1, 0);
      blk = enc(a, b, 3'b001, 3'b110);
      blk[72 + 60] = ~blk[72 + 60];
      send(blk); expect_out("R5 second beat data bit", a, b, 1, 0);
   endtask

   task automatic t_flag_err();
      logic [63:0] a = 64'hCAFE_F00D_8BAD_F00D;
      logic [63:0] b = 64'h7777_0000_9999_1111;
      logic [143:0] blk = enc(a, b, 3'b010, 3'b100);
      blk[65] = ~blk[65];
      send(blk); expect_out("R6 flag of inverted group", a, b, 1, 0);
      blk = enc(a, b, 3'b010, 3'b100);
      blk[72 + 64] = ~blk[72 + 64];
      send(blk); expect_out("R6 flag of plain group", a, b, 1, 0);
   endtask

   task automatic t_chk_err();
      logic [63:0] a = 64'hA5A5_5A5A_C3C3_3C3C;
      logic [63:0] b = 64'h0000_0001_8000_0000;
      logic [143:0] blk = enc(a, b, 3'b011, 3'b000);
      blk[68] = ~blk[68];
      send(blk); expect_out("R7 Hamming bit flip", a, b, 1, 0);
      blk = enc(a, b, 3'b011, 3'b000);
      blk[72 + 71] = ~blk[72 + 71];
      send(blk); expect_out("R7 parity bit flip", a, b, 1, 0);
   endtask

   task automatic t_double();
      logic [63:0] a = 64'h1111_2222_3333_4444;
      logic [63:0] b = 64'h5555_6666_7777_8888;
      logic [143:0] blk = enc(a, b, 3'b000, 3'b000);
      blk[3] = ~blk[3];
      blk[72 + 10] = ~blk[72 + 10];
      send(blk);
      expect_out("R8 double error", a ^ 64'h8, b ^ 64'h400, 0, 1);
   endtask

   task automatic t_outrange();
      logic [63:0] a = 64'h9E37_79B9_7F4A_7C15;
      logic [63:0] b = 64'hBF58_476D_1CE4_E5B9;
      logic [143:0] blk = enc(a, b, 3'b101, 3'b010);
      blk[72 + 69] = ~blk[72 + 69];
      blk[72 + 68] = ~blk[72 + 68];
      blk[70]      = ~blk[70];
      send(blk); expect_out("R9 syndrome 200 odd weight", a, b, 0, 1);
   endtask

   task automatic t_b2b();
      logic [63:0] a0 = 64'h0102_0304_0506_0708, b0 = 64'h1112_1314_1516_1718;
      logic [63:0] a1 = 64'h2122_2324_2526_2728, b1 = 64'h3132_3334_3536_3738;
      logic [143:0] k0 = enc(a0, b0, 3'b110, 3'b001);
      logic [143:0] k1 = enc(a1, b1, 3'b000, 3'b111);
      @(negedge clk); bv = 1'b1; beat = k0[71:0];
      @(negedge clk); beat = k0[143:72];
      @(negedge clk); expect_out("R10 first block", a0, b0, 0, 0);
      beat = k1[71:0];
      @(negedge clk); check("R10 gap cycle", 64'(ov), 64'd0);
      beat = k1[143:72];
      @(negedge clk); bv = 1'b0; beat = '0;
      expect_out("R10 second block", a1, b1, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_lone_beat();
      t_data_err();
      t_flag_err();
      t_chk_err();
      t_double();
      t_outrange();
      t_b2b();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule